// File: doc/BRIEF.md
# Indirect-Select Vectored Interrupt Controller

This block collects up to 128 interrupt lines and presents one interrupt request to a processor. Software reaches it through a simple 32-bit register bus. Per-source settings are never laid out as one register per source. Software first writes a source number into a select register. Every later mode, vector, enable, disable, set-pending, clear-pending and status access then applies only to that source. Each source has a 3-bit priority, a trigger type (low level, high level, falling edge or rising edge) and a vector word.

When the processor takes the interrupt, it reads the acknowledge register. That read returns the vector of the winning source, pushes the winner's priority and number onto an eight-entry nesting stack, and lowers the request line. Only a source with a strictly higher priority than the one in service can raise the line again. Each end-of-service write pops one stack entry. When no source qualifies, an acknowledge read returns the programmable spurious vector and changes nothing.

A three-state service machine drives the request line:
- QUIET: the stack is empty and nothing is requested.
- RAISED: a qualifying source exists and the line is high.
- HANDLING: at least one interrupt is in service and nothing preempts it.

The transitions are:
- QUIET to RAISED when a winner appears.
- RAISED to HANDLING on an acknowledge that finds a winner.
- RAISED falls back to HANDLING or QUIET if the winner vanishes before it is acknowledged.
- HANDLING to RAISED when a higher-priority source arrives.
- HANDLING to QUIET once the stack is empty.
- From any state, an acknowledge that finds a winner leads to HANDLING.

Top module: `isel_intc`

## Requirements
- R1: After reset the block is in this state. Every source is disabled and not pending. The mode of every source reads 0x40 (high level, priority 0). The stack is empty. The spurious vector is 0. `irq_o` is low.
- R2: Register byte offsets are: select 0x00, mode 0x04, vector 0x08, spurious 0x0C, acknowledge 0x10, current 0x14, end-of-service 0x18, enable 0x1C, disable 0x20, set-pending 0x24, clear-pending 0x28, status 0x2C. The select register keeps the low 7 bits written. Mode and vector accesses reach only the selected source. The mode register holds the priority in bits [2:0] and the trigger in bits [6:5]. Its other bits read as 0.
- R3: A write with bit 0 set to the enable register marks the selected source enabled. The same write to the disable register marks it disabled. Such writes with bit 0 clear have no effect. The status register shows the enable state in bit 0. A disabled source never raises `irq_o`.
- R4: A write with bit 0 set to the set-pending register makes the selected source pending. The same write to the clear-pending register clears a latched pending. The status register shows pending in bit 1.
- R5: Trigger 2'b11 latches pending on a rising edge and trigger 2'b01 on a falling edge. An acknowledge of that source clears the latch. A level that is held produces no new request.
- R6: Trigger 2'b10 (high) and trigger 2'b00 (low) make the source pending for as long as its line is at the active level. An acknowledge does not clear this.
- R7: Among enabled pending sources whose priority is strictly above the priority in service, the highest priority wins. A tie goes to the lowest source number.
- R8: An acknowledge read that finds a winner returns the winner's vector and pushes the winner onto the stack. `irq_o` is low in the following cycle. The current register then reads bit 8 set with the source number in bits [6:0].
- R9: An acknowledge read with no winner returns the spurious vector and pushes nothing. The current register reads 0 whenever the stack is empty.
- R10: Nesting reaches eight levels. A higher-priority source preempts the one in service. Each end-of-service write pops one level and restores the previous current source. Eight end-of-service writes always empty the stack, and further ones are ignored.
- R11: `irq_o` is registered. It rises one clock after a winner appears and stays high only while a winner exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | N_SRC | Interrupt source lines, synchronous to clk |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets priority ties and the strict-greater rule. A design that compared with greater-or-equal would re-raise the request for an equal-priority source during service, and one that scanned from the top index would acknowledge the wrong source of a tied pair. It fills the stack to all eight levels and unwinds it with exactly eight end-of-service writes plus one extra. An off-by-one pointer would then report a stale current source or leave the request line locked out. It also checks that an acknowledge clears edge-latched pending but not a held level, and that a spurious acknowledge leaves the current source unchanged.

// File: rtl/isel_intc_pkg.sv
package isel_intc_pkg;

    localparam int PRIO_W   = 3;
    localparam int NEST_MAX = 1 << PRIO_W;
    localparam int SEL_W    = 7;
    localparam int ADDR_W   = 6;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        ST_QUIET    = 2'd0,
        ST_RAISED   = 2'd1,
        ST_HANDLING = 2'd2
    } svc_e;

    localparam logic [ADDR_W-1:0] A_SELECT  = 6'h00;
    localparam logic [ADDR_W-1:0] A_MODE    = 6'h04;
    localparam logic [ADDR_W-1:0] A_VECTOR  = 6'h08;
    localparam logic [ADDR_W-1:0] A_SPUR    = 6'h0C;
    localparam logic [ADDR_W-1:0] A_ACK     = 6'h10;
    localparam logic [ADDR_W-1:0] A_CURRENT = 6'h14;
    localparam logic [ADDR_W-1:0] A_EOS     = 6'h18;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_DISABLE = 6'h20;
    localparam logic [ADDR_W-1:0] A_SETP    = 6'h24;
    localparam logic [ADDR_W-1:0] A_CLRP    = 6'h28;
    localparam logic [ADDR_W-1:0] A_STATUS  = 6'h2C;

endpackage

// File: rtl/isel_src_bank.sv
module isel_src_bank
    import isel_intc_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int VEC_W = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              sel_ok,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              mode_we,
    input  logic [PRIO_W-1:0] prio_wdata,
    input  logic [1:0]        trig_wdata,
    input  logic              vec_we,
    input  logic [VEC_W-1:0]  vec_wdata,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              set_cmd,
    input  logic              clr_cmd,
    input  logic              ack_hit,
    input  logic [IDX_W-1:0]  ack_idx,
    output logic [PRIO_W-1:0] prio_o [N_SRC],
    output logic [1:0]        trig_o [N_SRC],
    output logic [VEC_W-1:0]  vec_o  [N_SRC],
    output logic [N_SRC-1:0]  enab_o,
    output logic [N_SRC-1:0]  pend_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic              here;
        logic              edge_seen;
        logic              lvl_active;
        logic              line_r;
        logic              en_r;
        logic              latch_r;
        logic [PRIO_W-1:0] prio_r;
        logic [1:0]        trig_r;
        logic [VEC_W-1:0]  vec_r;

        assign here = sel_ok && (sel_idx == IDX_W'(g));

        always_comb begin
            unique case (trig_r)
                TRIG_RISE: edge_seen = src_i[g] & ~line_r;
                TRIG_FALL: edge_seen = ~src_i[g] & line_r;
                default:   edge_seen = 1'b0;
            endcase
        end

        assign lvl_active = ((trig_r == TRIG_HIGH) &&  src_i[g]) ||
                            ((trig_r == TRIG_LOW)  && !src_i[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_r  <= 1'b0;
                en_r    <= 1'b0;
                latch_r <= 1'b0;
                prio_r  <= '0;
                trig_r  <= TRIG_HIGH;
                vec_r   <= '0;
            end else begin
                line_r <= src_i[g];
                if (mode_we && here) begin
                    prio_r <= prio_wdata;
                    trig_r <= trig_wdata;
                end
                if (vec_we && here) vec_r <= vec_wdata;
                if (en_cmd && here)       en_r <= 1'b1;
                else if (dis_cmd && here) en_r <= 1'b0;
                if ((ack_hit && ack_idx == IDX_W'(g)) || (clr_cmd && here))
                    latch_r <= 1'b0;
                if (edge_seen || (set_cmd && here))
                    latch_r <= 1'b1;
            end
        end

        assign prio_o[g] = prio_r;
        assign trig_o[g] = trig_r;
        assign vec_o[g]  = vec_r;
        assign enab_o[g] = en_r;
        assign pend_o[g] = latch_r | lvl_active;

        assert_enable_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_cmd && here) |=> en_r);
        assert_disable_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (dis_cmd && here && !en_cmd) |=> !en_r);
        assert_edge_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
            edge_seen |=> pend_o[g]);
    end

endmodule

// File: rtl/isel_arbiter.sv
module isel_arbiter
    import isel_intc_pkg::*;
#(
    parameter int N_SRC = 128,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]  req,
    input  logic [PRIO_W-1:0] prio_i [N_SRC],
    input  logic              floor_valid,
    input  logic [PRIO_W-1:0] floor_prio,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx,
    output logic [PRIO_W-1:0] win_prio
);

    // Strict comparison keeps the lowest index on a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (!floor_valid || prio_i[i] > floor_prio) &&
                (!win_valid || prio_i[i] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/isel_nest_stack.sv
module isel_nest_stack
    import isel_intc_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int DEPTH = NEST_MAX,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    output logic              top_valid,
    output logic [PRIO_W-1:0] top_prio,
    output logic [IDX_W-1:0]  top_idx
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [IDX_W-1:0]  idx_q  [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  top_ptr;

    assign top_ptr   = cnt_q - CNT_W'(1);
    assign top_valid = (cnt_q != '0);
    assign top_prio  = prio_q[top_ptr[PTR_W-1:0]];
    assign top_idx   = idx_q[top_ptr[PTR_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                prio_q[i] <= '0;
                idx_q[i]  <= '0;
            end
        end else if (push && cnt_q != FULL) begin
            prio_q[cnt_q[PTR_W-1:0]] <= push_prio;
            idx_q[cnt_q[PTR_W-1:0]]  <= push_idx;
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && cnt_q != '0) begin
            cnt_q <= top_ptr;
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != FULL));
    assert_pop_unwind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/isel_intc.sv
module isel_intc
    import isel_intc_pkg::*;
#(
    parameter int N_SRC = 128,
    parameter int VEC_W = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);

    logic [SEL_W-1:0]  sel_q;
    logic [VEC_W-1:0]  spur_q;
    logic              sel_ok;
    logic [IDX_W-1:0]  sel_idx;
    logic              wr, rd, cmd_bit;
    logic              ack_rd, ack_hit, eos_wr;
    logic [PRIO_W-1:0] prio_a [N_SRC];
    logic [1:0]        trig_a [N_SRC];
    logic [VEC_W-1:0]  vec_a  [N_SRC];
    logic [N_SRC-1:0]  enab, pend;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic              top_valid;
    logic [PRIO_W-1:0] top_prio;
    logic [IDX_W-1:0]  top_idx;
    logic [31:0]       rd_val;
    svc_e              state_q, state_d;

    assign sel_ok  = ({1'b0, sel_q} < 8'(N_SRC));
    assign sel_idx = sel_q[IDX_W-1:0];
    assign wr      = bus_en && bus_we;
    assign rd      = bus_en && !bus_we;
    assign cmd_bit = bus_wdata[0];
    assign ack_rd  = rd && (bus_addr == A_ACK);
    assign ack_hit = ack_rd && win_valid;
    assign eos_wr  = wr && (bus_addr == A_EOS);

    isel_src_bank #(.N_SRC(N_SRC), .VEC_W(VEC_W)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .sel_ok     (sel_ok),
        .sel_idx    (sel_idx),
        .mode_we    (wr && bus_addr == A_MODE),
        .prio_wdata (bus_wdata[PRIO_W-1:0]),
        .trig_wdata (bus_wdata[6:5]),
        .vec_we     (wr && bus_addr == A_VECTOR),
        .vec_wdata  (bus_wdata[VEC_W-1:0]),
        .en_cmd     (wr && bus_addr == A_ENABLE && cmd_bit),
        .dis_cmd    (wr && bus_addr == A_DISABLE && cmd_bit),
        .set_cmd    (wr && bus_addr == A_SETP && cmd_bit),
        .clr_cmd    (wr && bus_addr == A_CLRP && cmd_bit),
        .ack_hit    (ack_hit),
        .ack_idx    (win_idx),
        .prio_o     (prio_a),
        .trig_o     (trig_a),
        .vec_o      (vec_a),
        .enab_o     (enab),
        .pend_o     (pend)
    );

    isel_arbiter #(.N_SRC(N_SRC)) i_arb (
        .req         (pend & enab),
        .prio_i      (prio_a),
        .floor_valid (top_valid),
        .floor_prio  (top_prio),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .win_prio    (win_prio)
    );

    isel_nest_stack #(.IDX_W(IDX_W)) i_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_hit),
        .push_prio (win_prio),
        .push_idx  (win_idx),
        .pop       (eos_wr),
        .top_valid (top_valid),
        .top_prio  (top_prio),
        .top_idx   (top_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            spur_q <= '0;
        end else if (wr) begin
            if (bus_addr == A_SELECT) sel_q  <= bus_wdata[SEL_W-1:0];
            if (bus_addr == A_SPUR)   spur_q <= bus_wdata[VEC_W-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            A_SELECT:  rd_val = 32'(sel_q);
            A_MODE:    rd_val = sel_ok ? {25'b0, trig_a[sel_idx], 2'b00, prio_a[sel_idx]} : '0;
            A_VECTOR:  rd_val = sel_ok ? 32'(vec_a[sel_idx]) : '0;
            A_SPUR:    rd_val = 32'(spur_q);
            A_ACK:     rd_val = win_valid ? 32'(vec_a[win_idx]) : 32'(spur_q);
            A_CURRENT: rd_val = top_valid ? {23'b0, 1'b1, 8'(top_idx)} : '0;
            A_STATUS:  rd_val = sel_ok ? {30'b0, pend[sel_idx], enab[sel_idx]} : '0;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_val;
    end

    // Service state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (ack_hit)        state_d = ST_HANDLING;
                else if (win_valid) state_d = ST_RAISED;
                else if (top_valid) state_d = ST_HANDLING;
            end
            ST_RAISED: begin
                if (ack_hit)         state_d = ST_HANDLING;
                else if (!win_valid) state_d = top_valid ? ST_HANDLING : ST_QUIET;
            end
            ST_HANDLING: begin
                if (ack_hit)         state_d = ST_HANDLING;
                else if (win_valid)  state_d = ST_RAISED;
                else if (!top_valid) state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // Output process
    always_comb irq_o = (state_q == ST_RAISED);

    assert_irq_needs_winner_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(win_valid));
    assert_irq_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !ack_rd) |=> irq_o);
    assert_ack_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> !irq_o);
    assert_ack_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (top_valid && top_prio == $past(win_prio)));
    assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !win_valid) |=> (bus_rdata == 32'($past(spur_q))));
    assert_above_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && top_valid) |-> (win_prio > top_prio));

endmodule

// File: tb/test_isel_intc.sv
module test_isel_intc;

    localparam logic [5:0] A_SELECT = 6'h00, A_MODE = 6'h04, A_VECTOR = 6'h08,
                           A_SPUR = 6'h0C, A_ACK = 6'h10, A_CURRENT = 6'h14,
                           A_EOS = 6'h18, A_ENABLE = 6'h1C, A_DISABLE = 6'h20,
                           A_SETP = 6'h24, A_CLRP = 6'h28, A_STATUS = 6'h2C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src = '0;
    logic         bus_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq;
    int           checks = 0;
    int           errors = 0;
    logic [31:0]  rv;

    always #4 clk = ~clk;

    isel_intc i_isel_intc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive(input int i, input logic v);
        @(negedge clk);
        src[i] = v;
    endtask

    task automatic config_src(input int i, input logic [31:0] mode, input logic [31:0] vec);
        wr(A_SELECT, i);
        wr(A_MODE, mode);
        wr(A_VECTOR, vec);
    endtask

    task automatic t_reset;
        chk("R1 irq low after reset", {31'b0, irq}, 32'h0);
        rd(A_STATUS, rv);  chk("R1 source 0 disabled, not pending", rv, 32'h0);
        rd(A_MODE, rv);    chk("R1 mode reset value", rv, 32'h40);
        rd(A_CURRENT, rv); chk("R1 R9 current empty", rv, 32'h0);
        rd(A_ACK, rv);     chk("R1 R9 spurious vector is zero", rv, 32'h0);
    endtask

    task automatic t_select;
        wr(A_SELECT, 32'h85);
        rd(A_SELECT, rv); chk("R2 select keeps low 7 bits", rv, 32'h05);
        config_src(5, 32'h62, 32'h1234_5005);
        wr(A_SELECT, 6);
        rd(A_MODE, rv);   chk("R2 neighbour mode untouched", rv, 32'h40);
        rd(A_VECTOR, rv); chk("R2 neighbour vector untouched", rv, 32'h0);
        wr(A_MODE, 32'hFF);
        rd(A_MODE, rv);   chk("R2 mode unused bits read zero", rv, 32'h67);
        wr(A_MODE, 32'h40);
        wr(A_SELECT, 5);
        rd(A_MODE, rv);   chk("R2 selected mode readback", rv, 32'h62);
        rd(A_VECTOR, rv); chk("R2 selected vector readback", rv, 32'h1234_5005);
    endtask

    task automatic t_enable;
        wr(A_SELECT, 5);
        wr(A_ENABLE, 32'h1);
        rd(A_STATUS, rv); chk("R3 enable sets status bit0", rv, 32'h1);
        wr(A_DISABLE, 32'h0);
        rd(A_STATUS, rv); chk("R3 disable with bit0 clear ignored", rv, 32'h1);
        wr(A_DISABLE, 32'h1);
        rd(A_STATUS, rv); chk("R3 disable clears status bit0", rv, 32'h0);
        wr(A_ENABLE, 32'h2);
        rd(A_STATUS, rv); chk("R3 enable with bit0 clear ignored", rv, 32'h0);
    endtask

    task automatic t_pend;
        wr(A_SELECT, 5);
        wr(A_SETP, 32'h1);
        rd(A_STATUS, rv); chk("R4 set makes pending", rv, 32'h2);
        idle(2);
        chk("R3 disabled pending source gives no irq", {31'b0, irq}, 32'h0);
        wr(A_CLRP, 32'h1);
        rd(A_STATUS, rv); chk("R4 clear removes pending", rv, 32'h0);
    endtask

    task automatic t_edge;
        wr(A_SELECT, 5);
        wr(A_ENABLE, 32'h1);
        drive(5, 1'b1); idle(2);
        chk("R5 R11 rising edge raises irq", {31'b0, irq}, 32'h1);
        rd(A_ACK, rv);     chk("R8 ack returns vector", rv, 32'h1234_5005);
        chk("R8 irq low after ack", {31'b0, irq}, 32'h0);
        rd(A_STATUS, rv);  chk("R5 ack clears edge pending", rv, 32'h1);
        rd(A_CURRENT, rv); chk("R8 current source number", rv, 32'h105);
        wr(A_EOS, 32'h0); idle(2);
        chk("R5 held high level no new request", {31'b0, irq}, 32'h0);
        drive(5, 1'b0); idle(2);
        chk("R5 falling edge ignored on rising type", {31'b0, irq}, 32'h0);
        wr(A_DISABLE, 32'h1);
        config_src(7, 32'h23, 32'h7007);
        drive(7, 1'b1); idle(2);
        rd(A_STATUS, rv);  chk("R5 rise ignored on falling type", rv, 32'h0);
        wr(A_ENABLE, 32'h1);
        drive(7, 1'b0); idle(2);
        chk("R5 falling edge raises irq", {31'b0, irq}, 32'h1);
        rd(A_ACK, rv);     chk("R5 falling source vector", rv, 32'h7007);
        wr(A_EOS, 32'h0);
        wr(A_DISABLE, 32'h1);
    endtask

    task automatic t_level;
        config_src(9, 32'h41, 32'h9009);
        wr(A_ENABLE, 32'h1);
        drive(9, 1'b1); idle(2);
        chk("R6 high level raises irq", {31'b0, irq}, 32'h1);
        rd(A_ACK, rv);    chk("R6 level vector", rv, 32'h9009);
        chk("R7 equal priority does not preempt", {31'b0, irq}, 32'h0);
        rd(A_STATUS, rv); chk("R6 ack keeps level pending", rv, 32'h3);
        wr(A_EOS, 32'h0); idle(2);
        chk("R6 level re-requests after service", {31'b0, irq}, 32'h1);
        rd(A_ACK, rv);    chk("R6 level second ack", rv, 32'h9009);
        wr(A_EOS, 32'h0);
        drive(9, 1'b0); idle(2);
        chk("R6 line low removes request", {31'b0, irq}, 32'h0);
        wr(A_DISABLE, 32'h1);
        drive(10, 1'b1);
        config_src(10, 32'h01, 32'hA00A);
        rd(A_STATUS, rv); chk("R6 low-level type idle when line high", rv, 32'h0);
        drive(10, 1'b0); idle(1);
        rd(A_STATUS, rv); chk("R6 low-level type pending when line low", rv, 32'h2);
        drive(10, 1'b1);
    endtask

    task automatic t_arb;
        wr(A_SPUR, 32'hDEAD_0000);
        for (int i = 20; i < 23; i++) begin
            config_src(i, (i == 22) ? 32'h62 : 32'h64, 32'hA0 + i);
            wr(A_ENABLE, 32'h1);
            wr(A_SETP, 32'h1);
        end
        idle(2);
        chk("R11 irq with pending set", {31'b0, irq}, 32'h1);
        rd(A_ACK, rv);     chk("R7 tie goes to lowest number", rv, 32'hB4);
        rd(A_CURRENT, rv); chk("R8 current after tie", rv, 32'h114);
        rd(A_ACK, rv);     chk("R9 R7 no winner above floor gives spurious", rv, 32'hDEAD_0000);
        rd(A_CURRENT, rv); chk("R9 spurious ack pushes nothing", rv, 32'h114);
        wr(A_EOS, 32'h0);
        rd(A_ACK, rv);     chk("R7 second of tie", rv, 32'hB5);
        wr(A_EOS, 32'h0);
        rd(A_ACK, rv);     chk("R7 lowest priority last", rv, 32'hB6);
        wr(A_EOS, 32'h0); idle(2);
        chk("R11 irq low when nothing pending", {31'b0, irq}, 32'h0);
        rd(A_ACK, rv);     chk("R9 spurious when idle", rv, 32'hDEAD_0000);
        for (int i = 20; i < 23; i++) begin
            wr(A_SELECT, i);
            wr(A_DISABLE, 32'h1);
        end
    endtask

    task automatic t_nest;
        for (int l = 0; l < 9; l++) begin
            config_src(30 + l, 32'h60 | ((l > 7) ? 7 : l), 32'hC0 + l);
            wr(A_ENABLE, 32'h1);
        end
        for (int l = 0; l < 8; l++) begin
            wr(A_SELECT, 30 + l);
            wr(A_SETP, 32'h1);
            idle(2);
            chk($sformatf("R10 level %0d preempts", l), {31'b0, irq}, 32'h1);
            rd(A_ACK, rv);
            chk($sformatf("R10 level %0d vector", l), rv, 32'hC0 + l);
        end
        rd(A_CURRENT, rv); chk("R10 eighth level current", rv, 32'h125);
        wr(A_SELECT, 38);
        wr(A_SETP, 32'h1); idle(2);
        chk("R7 equal top priority no irq", {31'b0, irq}, 32'h0);
        rd(A_ACK, rv);     chk("R9 full stack spurious", rv, 32'hDEAD_0000);
        wr(A_EOS, 32'h0);
        rd(A_CURRENT, rv); chk("R10 pop restores previous", rv, 32'h124);
        idle(1);
        chk("R10 preempt after pop", {31'b0, irq}, 32'h1);
        rd(A_ACK, rv);     chk("R10 refill eighth level", rv, 32'hC8);
        for (int k = 0; k < 8; k++) wr(A_EOS, 32'h0);
        rd(A_CURRENT, rv); chk("R10 eight pops empty stack", rv, 32'h0);
        wr(A_EOS, 32'h0); idle(2);
        rd(A_CURRENT, rv); chk("R10 extra pop ignored", rv, 32'h0);
        chk("R10 no lockout, irq idle", {31'b0, irq}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_select();
        t_enable();
        t_pend();
        t_edge();
        t_level();
        t_arb();
        t_nest();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule